// File: doc/BRIEF.md
# Multi-Memory SRAM Self-Test Sequencer

This block tests three on-chip SRAMs one after another: a receive FIFO buffer, a transmit FIFO buffer and a receive filter RAM. Each memory has its own address, write-data, write-enable and read-data port. The memories are expected to return read data in the same cycle as the address (asynchronous read), so every March operation that reads and then writes a location takes exactly one clock cycle. Each memory gets the six-element March C- sequence: ascending write 0; ascending read 0 and write 1; ascending read 1 and write 0; descending read 0 and write 1; descending read 1 and write 0; ascending read 0.

Software controls the engine through a small control/status word. One bit enables the engine, another holds it in its initial state. The status gives a completion flag, which is only set while the finished engine remains enabled, and one sticky failure flag per memory. A failure in one memory does not stop testing of the others. Clearing the enable bit mid-run aborts the sequence.

Top module: `sram_bist`

## Requirements
- R1: After hard reset (rstN low), every bit of csrRdata is 0 and no memory write enable is active.
- R2: A write with csrWdata[0]=1 (enable) and csrWdata[1]=0 (hold) while the enable bit is 0 starts a run. In the first cycle after that write edge, the receive FIFO is written with all zeros at address 0.
- R3: Each memory of depth D receives the March C- sequence in 6*D cycles. It gets 5*D writes. The first descending element begins at address D-1 writing all ones. After the run every word holds all zeros.
- R4: Memories are tested in the order receive FIFO, transmit FIFO, filter RAM. The first transmit write comes 6*RX_DEPTH cycles after the start, and the first filter write comes 6*(RX_DEPTH+TX_DEPTH) cycles after the start. At most one memory write enable is active in any cycle.
- R5: The done flag (csrRdata[2]) becomes 1 exactly 6*(RX_DEPTH+TX_DEPTH+FLT_DEPTH) cycles after the start edge. It reads 0 while running and whenever the enable bit is 0. No memory is written while it is 1.
- R6: The failure flags csrRdata[3] (receive FIFO), csrRdata[4] (transmit FIFO) and csrRdata[5] (filter RAM) are set when a read of that memory differs from the expected value. A failure changes neither the run length nor the testing of the other memories.
- R7: A failure flag stays set until the hold bit is written to 1, a new run starts, or a soft reset occurs. Clearing the enable bit does not clear it.
- R8: Writing the enable bit to 0 during a run aborts it: no further memory writes occur and done stays 0.
- R9: While the hold bit (csrWdata[1], read back on csrRdata[1]) is 1, the engine stays idle, all failure flags are 0, and writing the enable bit does not start a run.
- R10: A one-cycle soft reset pulse (softRst) clears the whole control/status word to 0 at the next edge and stops any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset, active high |
| csrWe | input | 1 | Control word write strobe |
| csrWdata | input | 2 | Write data: bit 0 enable, bit 1 hold |
| csrRdata | output | 6 | Status: enable, hold, done, rx fail, tx fail, filter fail (bits 0..5) |
| rxAddr | output | $clog2(RX_DEPTH) | Receive FIFO address |
| rxWdata | output | RX_WIDTH | Receive FIFO write data |
| rxWe | output | 1 | Receive FIFO write enable |
| rxRdata | input | RX_WIDTH | Receive FIFO read data (same cycle) |
| txAddr | output | $clog2(TX_DEPTH) | Transmit FIFO address |
| txWdata | output | TX_WIDTH | Transmit FIFO write data |
| txWe | output | 1 | Transmit FIFO write enable |
| txRdata | input | TX_WIDTH | Transmit FIFO read data (same cycle) |
| fltAddr | output | $clog2(FLT_DEPTH) | Filter RAM address |
| fltWdata | output | FLT_WIDTH | Filter RAM write data |
| fltWe | output | 1 | Filter RAM write enable |
| fltRdata | input | FLT_WIDTH | Filter RAM read data (same cycle) |

## Verification
A control word write is captured at one edge, and memory operation number i of a run is driven in the cycle after edge start+i. The first operation is therefore visible right after the start write, and done appears after edge start+6*(total depth), one cycle after the last operation. A failure flag is set at the edge that follows the mismatching read. The bench drives inputs and samples outputs at falling edges. It walks the run one cycle at a time with an index that matches this count, so each check of an address, a write count, a first-write cycle or done lands on the cycle where the value is due. Stuck-at faults are placed at random in the behavioural memories. The expected failure flags follow from which memory holds the fault.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;

  localparam int NUM_MEMS  = 3;
  localparam int NUM_ELEMS = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} bistState_e;

  typedef struct packed {
    logic       doRead;
    logic       doWrite;
    logic       wrOne;
    logic       expOne;
    logic       curDown;
    logic       stepAddr;
    logic       loadAddr;
    logic       loadDown;
    logic [1:0] loadMem;
    logic [1:0] memSel;
    logic       clearFail;
  } bistStrobe_t;

  // March C- element attributes, elements 0..5
  function automatic logic elemDown(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic elemRead(input logic [2:0] e);
    return e != 3'd0;
  endfunction

  function automatic logic elemWrite(input logic [2:0] e);
    return e != 3'd5;
  endfunction

  function automatic logic elemWrOne(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

  function automatic logic elemExpOne(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

endpackage

// File: rtl/sram_bist_ctrl.sv
module sram_bist_ctrl
  import sram_bist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        csrWe,
  input  logic [1:0]  csrWdata,
  input  logic        lastAddr,
  output bistStrobe_t strb,
  output logic        enableBit,
  output logic        holdBit,
  output logic        doneBit
);

  localparam logic [2:0] LAST_ELEM = 3'(NUM_ELEMS - 1);
  localparam logic [1:0] LAST_MEM  = 2'(NUM_MEMS - 1);

  bistState_e state, stateNext;
  logic [1:0] memSel, memNext;
  logic [2:0] elem, elemNext;
  logic       stopReq, startReq;

  always_comb begin
    stopReq  = softRst | (csrWe & (~csrWdata[0] | csrWdata[1]));
    startReq = csrWe & csrWdata[0] & ~csrWdata[1] & ~enableBit & ~softRst;
    strb        = '0;
    strb.memSel = memSel;
    stateNext   = state;
    memNext     = memSel;
    elemNext    = elem;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext      = ST_RUN;
          memNext        = '0;
          elemNext       = '0;
          strb.loadAddr  = 1'b1;
          strb.loadDown  = 1'b0;
          strb.loadMem   = '0;
          strb.clearFail = 1'b1;
        end
      end
      ST_RUN: begin
        strb.doRead  = elemRead(elem);
        strb.doWrite = elemWrite(elem);
        strb.wrOne   = elemWrOne(elem);
        strb.expOne  = elemExpOne(elem);
        strb.curDown = elemDown(elem);
        if (stopReq) begin
          stateNext = ST_IDLE;
        end else if (lastAddr) begin
          if (elem == LAST_ELEM) begin
            if (memSel == LAST_MEM) begin
              stateNext = ST_DONE;
            end else begin
              memNext       = 2'(memSel + 2'd1);
              elemNext      = '0;
              strb.loadAddr = 1'b1;
              strb.loadDown = 1'b0;
              strb.loadMem  = 2'(memSel + 2'd1);
            end
          end else begin
            elemNext      = 3'(elem + 3'd1);
            strb.loadAddr = 1'b1;
            strb.loadDown = elemDown(3'(elem + 3'd1));
            strb.loadMem  = memSel;
          end
        end else begin
          strb.stepAddr = 1'b1;
        end
      end
      ST_DONE: begin
        if (stopReq) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    strb.clearFail = strb.clearFail | softRst | holdBit | (csrWe & csrWdata[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      memSel    <= '0;
      elem      <= '0;
      enableBit <= 1'b0;
      holdBit   <= 1'b0;
    end else begin
      state  <= stateNext;
      memSel <= memNext;
      elem   <= elemNext;
      if (softRst) begin
        enableBit <= 1'b0;
        holdBit   <= 1'b0;
      end else if (csrWe) begin
        enableBit <= csrWdata[0];
        holdBit   <= csrWdata[1];
      end
    end
  end

  assign doneBit = (state == ST_DONE);

endmodule

// File: rtl/sram_bist_datapath.sv
module sram_bist_datapath
  import sram_bist_pkg::*;
#(
  parameter int RX_DEPTH  = 16,
  parameter int RX_WIDTH  = 8,
  parameter int TX_DEPTH  = 8,
  parameter int TX_WIDTH  = 16,
  parameter int FLT_DEPTH = 8,
  parameter int FLT_WIDTH = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bistStrobe_t                  strb,
  output logic                         lastAddr,
  output logic [NUM_MEMS-1:0]          failFlags,
  output logic [$clog2(RX_DEPTH)-1:0]  rxAddr,
  output logic [RX_WIDTH-1:0]          rxWdata,
  output logic                         rxWe,
  input  logic [RX_WIDTH-1:0]          rxRdata,
  output logic [$clog2(TX_DEPTH)-1:0]  txAddr,
  output logic [TX_WIDTH-1:0]          txWdata,
  output logic                         txWe,
  input  logic [TX_WIDTH-1:0]          txRdata,
  output logic [$clog2(FLT_DEPTH)-1:0] fltAddr,
  output logic [FLT_WIDTH-1:0]         fltWdata,
  output logic                         fltWe,
  input  logic [FLT_WIDTH-1:0]         fltRdata
);

  localparam int RX_AW  = $clog2(RX_DEPTH);
  localparam int TX_AW  = $clog2(TX_DEPTH);
  localparam int FLT_AW = $clog2(FLT_DEPTH);
  localparam int AW_A   = (RX_AW > TX_AW) ? RX_AW : TX_AW;
  localparam int AW     = (AW_A > FLT_AW) ? AW_A : FLT_AW;

  logic [AW-1:0]       addr;
  logic [NUM_MEMS-1:0] badVec;
  logic [NUM_MEMS-1:0] selVec;

  function automatic logic [AW-1:0] topAddr(input logic [1:0] sel);
    unique case (sel)
      2'd0:    return AW'(RX_DEPTH - 1);
      2'd1:    return AW'(TX_DEPTH - 1);
      default: return AW'(FLT_DEPTH - 1);
    endcase
  endfunction

  assign lastAddr = strb.curDown ? (addr == '0) : (addr == topAddr(strb.memSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addr <= '0;
    else if (strb.loadAddr) addr <= strb.loadDown ? topAddr(strb.loadMem) : '0;
    else if (strb.stepAddr) addr <= strb.curDown ? AW'(addr - 1'b1) : AW'(addr + 1'b1);
  end

  for (genvar k = 0; k < NUM_MEMS; k++) begin : g_sel
    assign selVec[k] = (strb.memSel == 2'(k));
  end

  assign rxAddr   = addr[RX_AW-1:0];
  assign txAddr   = addr[TX_AW-1:0];
  assign fltAddr  = addr[FLT_AW-1:0];
  assign rxWdata  = {RX_WIDTH{strb.wrOne}};
  assign txWdata  = {TX_WIDTH{strb.wrOne}};
  assign fltWdata = {FLT_WIDTH{strb.wrOne}};
  assign rxWe     = strb.doWrite & selVec[0];
  assign txWe     = strb.doWrite & selVec[1];
  assign fltWe    = strb.doWrite & selVec[2];

  assign badVec[0] = rxRdata  != {RX_WIDTH{strb.expOne}};
  assign badVec[1] = txRdata  != {TX_WIDTH{strb.expOne}};
  assign badVec[2] = fltRdata != {FLT_WIDTH{strb.expOne}};

  for (genvar k = 0; k < NUM_MEMS; k++) begin : g_fail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     failFlags[k] <= 1'b0;
      else if (strb.clearFail)                       failFlags[k] <= 1'b0;
      else if (strb.doRead && selVec[k] && badVec[k]) failFlags[k] <= 1'b1;
    end
  end

endmodule

// File: rtl/sram_bist.sv
module sram_bist
  import sram_bist_pkg::*;
#(
  parameter int RX_DEPTH  = 16,
  parameter int RX_WIDTH  = 8,
  parameter int TX_DEPTH  = 8,
  parameter int TX_WIDTH  = 16,
  parameter int FLT_DEPTH = 8,
  parameter int FLT_WIDTH = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         softRst,
  input  logic                         csrWe,
  input  logic [1:0]                   csrWdata,
  output logic [5:0]                   csrRdata,
  output logic [$clog2(RX_DEPTH)-1:0]  rxAddr,
  output logic [RX_WIDTH-1:0]          rxWdata,
  output logic                         rxWe,
  input  logic [RX_WIDTH-1:0]          rxRdata,
  output logic [$clog2(TX_DEPTH)-1:0]  txAddr,
  output logic [TX_WIDTH-1:0]          txWdata,
  output logic                         txWe,
  input  logic [TX_WIDTH-1:0]          txRdata,
  output logic [$clog2(FLT_DEPTH)-1:0] fltAddr,
  output logic [FLT_WIDTH-1:0]         fltWdata,
  output logic                         fltWe,
  input  logic [FLT_WIDTH-1:0]         fltRdata
);

  bistStrobe_t         strb;
  logic                lastAddr;
  logic [NUM_MEMS-1:0] failFlags;
  logic                enableBit, holdBit, doneBit;

  sram_bist_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .softRst   (softRst),
    .csrWe     (csrWe),
    .csrWdata  (csrWdata),
    .lastAddr  (lastAddr),
    .strb      (strb),
    .enableBit (enableBit),
    .holdBit   (holdBit),
    .doneBit   (doneBit)
  );

  sram_bist_datapath #(
    .RX_DEPTH (RX_DEPTH),  .RX_WIDTH (RX_WIDTH),
    .TX_DEPTH (TX_DEPTH),  .TX_WIDTH (TX_WIDTH),
    .FLT_DEPTH(FLT_DEPTH), .FLT_WIDTH(FLT_WIDTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lastAddr  (lastAddr),
    .failFlags (failFlags),
    .rxAddr    (rxAddr),
    .rxWdata   (rxWdata),
    .rxWe      (rxWe),
    .rxRdata   (rxRdata),
    .txAddr    (txAddr),
    .txWdata   (txWdata),
    .txWe      (txWe),
    .txRdata   (txRdata),
    .fltAddr   (fltAddr),
    .fltWdata  (fltWdata),
    .fltWe     (fltWe),
    .fltRdata  (fltRdata)
  );

  assign csrRdata = {failFlags, doneBit, holdBit, enableBit};

endmodule

// File: rtl/sram_bist_chk.sv
module sram_bist_chk (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic       csrWe,
  input logic [5:0] csrRdata,
  input logic       rxWe,
  input logic       txWe,
  input logic       fltWe
);

  // R4
  we_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxWe, txWe, fltWe}));

  // R5
  done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrRdata[2] |-> csrRdata[0]);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrRdata[2] |-> !(rxWe || txWe || fltWe));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && !csrWe) |=> ((csrRdata[5:3] & $past(csrRdata[5:3])) == $past(csrRdata[5:3])));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrRdata[1] |-> !(rxWe || txWe || fltWe || csrRdata[2]));

  // R9
  hold_nofail_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrRdata[1] |-> (csrRdata[5:3] == 3'b000));

  // R10
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (csrRdata == 6'd0));

endmodule

bind sram_bist sram_bist_chk u_chk (.*);

// File: tb/sram_bist_tb.sv
`timescale 1ns/1ps
module sram_bist_tb;

  localparam int RXD = 16, RXW = 8, TXD = 8, TXW = 16, FLD = 8, FLW = 4;
  localparam int TOTAL = 6 * (RXD + TXD + FLD);
  localparam int RXA = $clog2(RXD), TXA = $clog2(TXD), FLA = $clog2(FLD);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic csrWe = 1'b0;
  logic [1:0] csrWdata = '0;
  logic [5:0] csrRdata;
  logic [RXA-1:0] rxAddr;  logic [RXW-1:0] rxWdata, rxRdata;  logic rxWe;
  logic [TXA-1:0] txAddr;  logic [TXW-1:0] txWdata, txRdata;  logic txWe;
  logic [FLA-1:0] fltAddr; logic [FLW-1:0] fltWdata, fltRdata; logic fltWe;

  int total = 0;
  int bad = 0;

  logic [RXW-1:0] rxMem [RXD];
  logic [TXW-1:0] txMem [TXD];
  logic [FLW-1:0] flMem [FLD];

  // stuck-at fault: memory index (3 = none), address, bit, stuck value
  int fMem = 3, fAddr = 0, fBit = 0;
  logic fVal = 1'b0;

  always #10 clk = ~clk;

  sram_bist #(.RX_DEPTH(RXD), .RX_WIDTH(RXW), .TX_DEPTH(TXD), .TX_WIDTH(TXW),
              .FLT_DEPTH(FLD), .FLT_WIDTH(FLW)) u_dut (.*);

  always @(posedge clk) begin
    if (rxWe)  rxMem[rxAddr]  <= rxWdata;
    if (txWe)  txMem[txAddr]  <= txWdata;
    if (fltWe) flMem[fltAddr] <= fltWdata;
  end

  always_comb begin
    rxRdata  = rxMem[rxAddr];
    txRdata  = txMem[txAddr];
    fltRdata = flMem[fltAddr];
    if (fMem == 0 && int'(rxAddr)  == fAddr) rxRdata[fBit]  = fVal;
    if (fMem == 1 && int'(txAddr)  == fAddr) txRdata[fBit]  = fVal;
    if (fMem == 2 && int'(fltAddr) == fAddr) fltRdata[fBit] = fVal;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [1:0] v);
    csrWe = 1'b1; csrWdata = v;
    @(negedge clk);
    csrWe = 1'b0; csrWdata = '0;
  endtask

  function automatic logic [2:0] failFor(input int m);
    return (m < 3) ? 3'(1 << m) : 3'b000;
  endfunction

  task automatic runFull(input int m);
    int rxN = 0, txN = 0, flN = 0, txFirst = -1, flFirst = -1;
    logic doneEarly = 1'b0;
    logic allZero = 1'b1;
    csrWrite(2'b00);
    csrWrite(2'b01);
    check(rxWe && rxAddr == 0 && rxWdata == 0, "R2 first op", {rxWe, rxAddr, rxWdata}, 32'h1000);
    check(csrRdata[5:3] == 0, "R7 start clears fails", csrRdata[5:3], 0);
    for (int i = 0; i < TOTAL; i++) begin
      if (rxWe) rxN++;
      if (txWe) begin txN++; if (txFirst < 0) txFirst = i; end
      if (fltWe) begin flN++; if (flFirst < 0) flFirst = i; end
      if (csrRdata[2]) doneEarly = 1'b1;
      if (i == 3 * RXD)
        check(rxWe && rxAddr == RXA'(RXD - 1) && rxWdata == '1, "R3 descending start",
              {rxWe, rxAddr, rxWdata}, {1'b1, RXA'(RXD - 1), {RXW{1'b1}}});
      @(negedge clk);
    end
    check(!doneEarly, "R5 done low while running", doneEarly, 0);
    check(csrRdata[2], "R5 done on time", csrRdata[2], 1);
    check(csrRdata[5:3] == failFor(m), "R6 fail flags", csrRdata[5:3], failFor(m));
    check(rxN == 5 * RXD && txN == 5 * TXD && flN == 5 * FLD, "R3 write counts",
          rxN * 65536 + txN * 256 + flN, 5 * RXD * 65536 + 5 * TXD * 256 + 5 * FLD);
    check(txFirst == 6 * RXD && flFirst == 6 * (RXD + TXD), "R4 memory order",
          txFirst * 1024 + flFirst, 6 * RXD * 1024 + 6 * (RXD + TXD));
    for (int a = 0; a < RXD; a++) if (rxMem[a] != 0) allZero = 1'b0;
    for (int a = 0; a < TXD; a++) if (txMem[a] != 0) allZero = 1'b0;
    for (int a = 0; a < FLD; a++) if (flMem[a] != 0) allZero = 1'b0;
    check(allZero, "R3 final contents zero", allZero, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_B157);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csrRdata == 0 && !(rxWe || txWe || fltWe), "R1 reset state", csrRdata, 0);

    // directed: no fault, then random faults
    runFull(3);
    for (int t = 0; t < 8; t++) begin
      fMem = $urandom % 4;
      fAddr = (fMem == 0) ? $urandom % RXD : (fMem == 1) ? $urandom % TXD : $urandom % FLD;
      fBit = (fMem == 0) ? $urandom % RXW : (fMem == 1) ? $urandom % TXW : $urandom % FLW;
      fVal = 1'($urandom % 2);
      runFull(fMem);
    end

    // directed: stuck-at-1 at transmit FIFO top address
    fMem = 1; fAddr = TXD - 1; fBit = TXW - 1; fVal = 1'b1;
    runFull(1);
    csrWrite(2'b00);
    check(csrRdata[5:3] == 3'b010, "R7 fail kept after disable", csrRdata[5:3], 2);
    check(!csrRdata[2], "R5 done low when disabled", csrRdata[2], 0);
    csrWrite(2'b10);
    check(csrRdata == 6'b000010, "R9 hold clears fails", csrRdata, 2);
    csrWrite(2'b11);
    begin
      logic moved = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (rxWe || txWe || fltWe || csrRdata[2]) moved = 1'b1;
        @(negedge clk);
      end
      check(!moved && csrRdata == 6'b000011, "R9 start ignored under hold", {moved, csrRdata}, 3);
    end
    csrWrite(2'b00);

    // abort mid-run
    fMem = 3;
    csrWrite(2'b01);
    repeat (1 + $urandom % (TOTAL - 2)) @(negedge clk);
    csrWrite(2'b00);
    begin
      logic moved = 1'b0;
      for (int i = 0; i < TOTAL + 5; i++) begin
        if (rxWe || txWe || fltWe || csrRdata[2]) moved = 1'b1;
        @(negedge clk);
      end
      check(!moved, "R8 abort stops writes and done", moved, 0);
    end

    // soft reset mid-run
    csrWrite(2'b01);
    repeat (20) @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check(csrRdata == 0 && !(rxWe || txWe || fltWe), "R10 soft reset clears", csrRdata, 0);

    // run completes normally after soft reset, fault in filter RAM
    fMem = 2; fAddr = 0; fBit = 0; fVal = 1'b0;
    runFull(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule